// File: doc/BRIEF.md
# Closed-Caption Capture Register Block

This block sits behind a line-21 caption slicer in a 525-line video decoder. Each time the slicer recovers a two-byte caption pair, it pulses a strobe, names the field the pair came from, and presents the two raw bytes. The block keeps the most recent pair. In each stored byte, the top bit is replaced by the result of an odd-parity check. Field 1 carries captions and field 2 carries extended data services. The block handles both fields the same way.

A host reads three byte-wide registers through a simple read port: the first caption byte, the second caption byte and a status byte. The status byte has a valid flag and a ready flag for each field. A field's valid flag is set when the slicer reports caption content in that field, and clears after four consecutive frames with nothing. A field's ready flag is set when a new pair for that field arrives. It clears when the host reads the second byte of that pair. A host can therefore read once per field in step with the video timing, or it can poll the status byte.

Top module: `cc_capture_regs`

## Requirements
- R1: After reset, all three registers and `rdData` read as 0x00.
- R2: On `pairStrobe`, the low 7 bits of `rawByteA` are stored at address 0x1A, and the low 7 bits of `rawByteB` are stored at address 0x1B.
- R3: Bit 7 of each stored byte is 1 when the raw 8-bit byte holds an odd number of ones, and 0 otherwise.
- R4: A pair with `pairField`=0 sets status bit 2 (field 1 ready). A pair with `pairField`=1 sets status bit 3 (field 2 ready).
- R5: A read of 0x1B clears the ready flag of the field that the latest stored pair came from. It does not touch the other field's flag. Reads of 0x1A and 0x1C clear nothing.
- R6: If a pair arrives in the same cycle as a read of 0x1B, the read returns the previous second byte, and the new pair's ready flag ends set.
- R7: A `fieldEnd` pulse with `capPresent`=1 sets the valid flag of field `fieldEndId`. Field 1 valid is status bit 0 and field 2 valid is status bit 1.
- R8: A field's valid flag clears on the 4th consecutive `fieldEnd` of that field with `capPresent`=0. Fewer than 4 leave it set, and a pulse with `capPresent`=1 restarts the count.
- R9: `rdData` shows the addressed register one cycle after `rdEn`, taken from its value before that edge. Addresses outside 0x1A–0x1C return 0x00. `rdData` holds its value while `rdEn` is low.
- R10: Status bits 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pairStrobe | input | 1 | A decoded caption pair is on the raw byte inputs |
| pairField | input | 1 | Field of the pair (0 = field 1, 1 = field 2) |
| rawByteA | input | 8 | First raw caption byte |
| rawByteB | input | 8 | Second raw caption byte |
| fieldEnd | input | 1 | Caption window of a field has closed |
| fieldEndId | input | 1 | Field that `fieldEnd` refers to |
| capPresent | input | 1 | Caption content was detected in that field |
| rdEn | input | 1 | Host read request |
| rdAddr | input | 8 | Host read address |
| rdData | output | 8 | Registered read data |

## Verification
The bench uses byte patterns with even and odd numbers of ones, including all-zero and all-one bytes, so a design with inverted or even parity would produce the wrong top bit. It clears ready from the field of the latest pair while the other field's flag is still set. A design that clears both flags, or clears on the first-byte read, would then show the wrong status. It collides a new pair with a second-byte read, which exposes a design where the clear wins or the read returns the new byte. It steps the miss count to three and four and restarts it, which catches an off-by-one timeout or a count that is never reset.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  localparam int NUM_FIELDS = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_B1   = 2'd1,
    SEL_B2   = 2'd2,
    SEL_STAT = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   loadPair;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/ccap_ctrl.sv
module ccap_ctrl
  import ccap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1A,
  parameter int MISS_LIMIT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pairStrobe,
  input  logic                  pairField,
  input  logic                  fieldEnd,
  input  logic                  fieldEndId,
  input  logic                  capPresent,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output ctrlStrobe_t           strb,
  output logic [NUM_FIELDS-1:0] validQ,
  output logic [NUM_FIELDS-1:0] rdyQ
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);

  logic [ADDR_W-1:0] offs;
  rdSel_e sel;
  logic lastFieldQ;

  assign offs = rdAddr - BASE_ADDR;

  always_comb begin
    sel = SEL_NONE;
    if (offs == ADDR_W'(0))      sel = SEL_B1;
    else if (offs == ADDR_W'(1)) sel = SEL_B2;
    else if (offs == ADDR_W'(2)) sel = SEL_STAT;
  end

  assign strb.loadPair = pairStrobe;
  assign strb.rdEn     = rdEn;
  assign strb.rdSel    = sel;

  always_ff @(posedge clk) begin
    if (!rstN)           lastFieldQ <= 1'b0;
    else if (pairStrobe) lastFieldQ <= pairField;
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic setRdy, clrRdy, endHere;
    logic [MISS_W-1:0] missQ;

    assign setRdy  = pairStrobe && (pairField == 1'(f));
    assign clrRdy  = rdEn && (sel == SEL_B2) && (lastFieldQ == 1'(f));
    assign endHere = fieldEnd && (fieldEndId == 1'(f));

    always_ff @(posedge clk) begin
      if (!rstN)       rdyQ[f] <= 1'b0;
      else if (setRdy) rdyQ[f] <= 1'b1;
      else if (clrRdy) rdyQ[f] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[f] <= 1'b0;
        missQ     <= '0;
      end else if (endHere) begin
        if (capPresent) begin
          validQ[f] <= 1'b1;
          missQ     <= '0;
        end else if (missQ == MISS_W'(MISS_LIMIT - 1)) begin
          validQ[f] <= 1'b0;
        end else begin
          missQ <= missQ + 1'b1;
        end
      end
    end

    p_rdy_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      (pairStrobe && pairField == 1'(f)) |=> rdyQ[f]);
    p_rdy_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
      (rdyQ[f] && !(rdEn && rdAddr == BASE_ADDR + ADDR_W'(1))) |=> rdyQ[f]);
    p_valid_set_r7: assert property (@(posedge clk) disable iff (!rstN)
      (fieldEnd && fieldEndId == 1'(f) && capPresent) |=> validQ[f]);
    p_valid_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
      (validQ[f] && !(fieldEnd && fieldEndId == 1'(f) && !capPresent)) |=> validQ[f]);
  end
endmodule

// File: rtl/ccap_datapath.sv
module ccap_datapath
  import ccap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [DATA_W-1:0]     rawByteA,
  input  logic [DATA_W-1:0]     rawByteB,
  input  logic [NUM_FIELDS-1:0] validQ,
  input  logic [NUM_FIELDS-1:0] rdyQ,
  output logic [DATA_W-1:0]     rdData
);
  localparam int PAD_W = DATA_W - 2 * NUM_FIELDS;

  logic [DATA_W-1:0] byteAQ, byteBQ, statusW, rdNext;

  function automatic logic [DATA_W-1:0] tagParity(input logic [DATA_W-1:0] raw);
    return {^raw, raw[DATA_W-2:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteAQ <= '0;
      byteBQ <= '0;
    end else if (strb.loadPair) begin
      byteAQ <= tagParity(rawByteA);
      byteBQ <= tagParity(rawByteB);
    end
  end

  assign statusW = {{PAD_W{1'b0}}, rdyQ, validQ};

  always_comb begin
    case (strb.rdSel)
      SEL_B1:   rdNext = byteAQ;
      SEL_B2:   rdNext = byteBQ;
      SEL_STAT: rdNext = statusW;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  p_low_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPair |=> (byteAQ[DATA_W-2:0] == $past(rawByteA[DATA_W-2:0]) &&
                       byteBQ[DATA_W-2:0] == $past(rawByteB[DATA_W-2:0])));
  p_parity_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPair |=> (^byteAQ == $past(rawByteA[DATA_W-1])));
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_NONE) |=> (rdData == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));
  p_status_pad_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.rdSel == SEL_STAT) |=> (rdData[DATA_W-1:2*NUM_FIELDS] == '0));
endmodule

// File: rtl/cc_capture_regs.sv
module cc_capture_regs
  import ccap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1A,
  parameter int MISS_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pairStrobe,
  input  logic              pairField,
  input  logic [DATA_W-1:0] rawByteA,
  input  logic [DATA_W-1:0] rawByteB,
  input  logic              fieldEnd,
  input  logic              fieldEndId,
  input  logic              capPresent,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobe_t strb;
  logic [NUM_FIELDS-1:0] validQ, rdyQ;

  ccap_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MISS_LIMIT(MISS_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .pairStrobe(pairStrobe), .pairField(pairField),
    .fieldEnd(fieldEnd), .fieldEndId(fieldEndId), .capPresent(capPresent),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb), .validQ(validQ), .rdyQ(rdyQ)
  );

  ccap_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rawByteA(rawByteA), .rawByteB(rawByteB),
    .validQ(validQ), .rdyQ(rdyQ), .rdData(rdData)
  );
endmodule

// File: tb/test_cc_capture_regs.sv
module test_cc_capture_regs;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] A_B1 = 8'h1A, A_B2 = 8'h1B, A_ST = 8'h1C;
  // {rawA, rawB, field, expected byte at 0x1A, expected byte at 0x1B}
  localparam logic [32:0] VEC [6] = '{
    {8'h00, 8'h01, 1'b0, 8'h00, 8'h81},
    {8'h7F, 8'hFF, 1'b1, 8'hFF, 8'h7F},
    {8'h80, 8'h41, 1'b0, 8'h80, 8'h41},
    {8'h55, 8'hD5, 1'b1, 8'h55, 8'hD5},
    {8'h03, 8'h83, 1'b0, 8'h03, 8'h83},
    {8'hAA, 8'h2A, 1'b1, 8'h2A, 8'hAA}
  };

  logic clk = 0, rstN = 0;
  logic pairStrobe = 0, pairField = 0, fieldEnd = 0, fieldEndId = 0, capPresent = 0, rdEn = 0;
  logic [7:0] rawByteA = 0, rawByteB = 0, rdAddr = 0, rdData;
  int nChecks = 0, nFail = 0;
  logic [1:0] rdyM = 0;
  logic lastF = 0;
  logic [7:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_capture_regs i_cc_capture_regs (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); rdEn = 1; rdAddr = a;
    @(negedge clk); rdEn = 0; v = rdData;
  endtask

  task automatic sendPair(input logic [7:0] a, input logic [7:0] b, input logic f);
    @(negedge clk); pairStrobe = 1; rawByteA = a; rawByteB = b; pairField = f;
    @(negedge clk); pairStrobe = 0;
    rdyM[f] = 1'b1; lastF = f;
  endtask

  task automatic endField(input logic f, input logic p);
    @(negedge clk); fieldEnd = 1; fieldEndId = f; capPresent = p;
    @(negedge clk); fieldEnd = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 rdData", rdData, 8'h00);
    doRead(A_B1, d); check("R1 byte1", d, 8'h00);
    doRead(A_B2, d); check("R1 byte2", d, 8'h00);
    doRead(A_ST, d); check("R1 status", d, 8'h00);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < 6; i++) begin
      sendPair(VEC[i][32:25], VEC[i][24:17], VEC[i][16]);
      doRead(A_ST, d); check("R4 ready after pair", d, {4'h0, rdyM, 2'b00});
      doRead(A_B1, d); check("R2/R3 byte1", d, VEC[i][15:8]);
      doRead(A_B2, d); check("R2/R3 byte2", d, VEC[i][7:0]);
      rdyM[lastF] = 1'b0;
      doRead(A_ST, d); check("R5 ready after byte2 read", d, {4'h0, rdyM, 2'b00});
    end

    // R5: other field kept, 0x1A/0x1C reads clear nothing
    sendPair(8'h11, 8'h22, 1'b0);
    sendPair(8'h33, 8'h44, 1'b1);
    doRead(A_B1, d);
    doRead(A_ST, d); check("R5 no clear on 1A/1C", d, 8'h0C);
    doRead(A_B2, d);
    doRead(A_ST, d); check("R5 clears only latest field", d, 8'h04);
    doRead(A_B2, d);
    doRead(A_ST, d); check("R5 field1 kept", d, 8'h04);

    // R6: pair collides with 0x1B read
    sendPair(8'h01, 8'h02, 1'b0);   // stored byte2 = 82
    @(negedge clk); rdEn = 1; rdAddr = A_B2; pairStrobe = 1; pairField = 0;
    rawByteA = 8'h10; rawByteB = 8'h20;
    @(negedge clk); rdEn = 0; pairStrobe = 0;
    check("R6 read returns old byte2", rdData, 8'h82);
    doRead(A_ST, d); check("R6 ready stays set", d, 8'h04);
    doRead(A_B2, d); check("R6 new byte2 stored", d, 8'hA0);
    doRead(A_ST, d); check("R6 cleared by later read", d, 8'h00);

    // R7 R8 valid tracking
    endField(1'b0, 1'b1);
    doRead(A_ST, d); check("R7 field1 valid", d, 8'h01);
    endField(1'b1, 1'b1);
    doRead(A_ST, d); check("R7 field2 valid", d, 8'h03);
    for (int k = 0; k < 3; k++) endField(1'b0, 1'b0);
    doRead(A_ST, d); check("R8 three misses keep valid", d, 8'h03);
    endField(1'b0, 1'b1);
    for (int k = 0; k < 3; k++) endField(1'b0, 1'b0);
    doRead(A_ST, d); check("R8 presence restarts count", d, 8'h03);
    endField(1'b0, 1'b0);
    doRead(A_ST, d); check("R8 fourth miss clears field1", d, 8'h02);
    for (int k = 0; k < 4; k++) endField(1'b1, 1'b0);
    doRead(A_ST, d); check("R8 field2 cleared", d, 8'h00);

    // R9 address range and hold
    sendPair(8'h7F, 8'h00, 1'b1);
    doRead(8'h19, d); check("R9 below range", d, 8'h00);
    doRead(A_B1, d);
    doRead(8'h1D, d); check("R9 above range", d, 8'h00);
    doRead(A_B1, d); check("R9 byte1", d, 8'hFF);
    repeat (3) @(negedge clk);
    check("R9 hold while idle", rdData, 8'hFF);
    // R10 status padding
    doRead(A_ST, d); check("R10 upper status bits zero", d & 8'hF0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule